// File: doc/BRIEF.md
# Host Reset Pulse Generator

This block turns a single request strobe into one of two timed, active-low reset pulses for a host processor complex. A cold request pulls the system reset line low long enough to pass the downstream debounce filter on that line, which ignores anything shorter than 16 ms. The default hold is 20 ms. A warm request pulls a separate processor init line low for a short pulse of about 10 µs. A warm reset leaves the system reset line and power untouched.

The requester drives `reqValid` for one cycle and uses `reqCold` to choose the pulse type. The block also watches the present level of the system reset line through `sysRstSense`. If that line is already low, a cold request is dropped, because another agent is already holding the platform in reset. While a pulse is running, `busy` is high and any new request is ignored. Both pulse widths are parameters counted in clock cycles.

Top module: `reset_pulse_top`

## Requirements
- R1: In the first cycle after a synchronous reset, `sysRstN` and `initN` are both 1 and `busy` is 0.
- R2: A cold request (`reqValid`=1, `reqCold`=1, `sysRstSense`=1, `busy`=0) sampled at a clock edge drives `sysRstN` low from that edge for exactly `COLD_HOLD_CYCLES` cycles, after which it returns to 1.
- R3: A cold request sampled while `sysRstSense` is 0 is ignored: `sysRstN` stays 1 and `busy` stays 0.
- R4: A warm request (`reqValid`=1, `reqCold`=0, `busy`=0) sampled at a clock edge drives `initN` low from that edge for exactly `WARM_PULSE_CYCLES` cycles, after which it returns to 1.
- R5: A warm pulse never moves `sysRstN`, a cold pulse never moves `initN`, and the two lines are never low together.
- R6: `busy` is 1 exactly in the cycles where one of the two lines is being held low.
- R7: A request sampled while `busy` is 1 has no effect: the running pulse is neither stretched nor restarted, and the other line does not move.
- R8: Every warm pulse lasts at least 500 ns at the clock rate given by `CLK_FREQ_HZ`.
- R9: A request sampled in the first cycle in which `busy` is low again is accepted, with no dead cycle after the previous pulse.
- R10: The level of `sysRstSense` has no effect on warm requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | One-cycle request strobe |
| reqCold | input | 1 | 1 selects a cold reset, 0 selects a warm reset |
| sysRstSense | input | 1 | Present level of the system reset line |
| sysRstN | output | 1 | System reset line drive, active low |
| initN | output | 1 | Processor init line drive, active low |
| busy | output | 1 | A pulse is in progress |

## Verification
On every cycle the assertions check the following:
- The two lines are never low together.
- `busy` agrees with the line levels.
- No new falling edge appears while `busy` is high.
- A cold request is refused when the sensed line is low.
- The measured length of each low run matches its parameter, and a warm run is never shorter than the 500 ns floor.

Some behaviour needs the bench's stimulus. One case is a request landing on the exact cycle that `busy` clears. Others are a cold request arriving in the middle of a warm pulse and a warm request made while the sense line is low. The bench also checks that long random request streams track an independent reference model cycle by cycle.

// File: rtl/reset_pulse_pkg.sv
package reset_pulse_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_COLD = 2'd1,
    PS_WARM = 2'd2
  } pulseState_e;

  typedef struct packed {
    logic startCold;
    logic startWarm;
    logic finish;
  } pulseStrobes_t;

endpackage

// File: rtl/reset_pulse_ctrl.sv
module reset_pulse_ctrl
  import reset_pulse_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  input  logic          reqCold,
  input  logic          sysRstSense,
  input  logic          cntZero,
  output pulseStrobes_t strobes,
  output logic          busy
);

  pulseState_e stateQ;
  pulseState_e stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      PS_IDLE: begin
        if (reqValid) begin
          if (!reqCold) begin
            strobes.startWarm = 1'b1;
            stateD            = PS_WARM;
          end else if (sysRstSense) begin
            strobes.startCold = 1'b1;
            stateD            = PS_COLD;
          end
        end
      end
      PS_COLD, PS_WARM: begin
        if (cntZero) begin
          strobes.finish = 1'b1;
          stateD         = PS_IDLE;
        end
      end
      default: begin
        strobes.finish = 1'b1;
        stateD         = PS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= PS_IDLE;
    else     stateQ <= stateD;
  end

  assign busy = (stateQ != PS_IDLE);

endmodule

// File: rtl/reset_pulse_datapath.sv
module reset_pulse_datapath
  import reset_pulse_pkg::*;
#(
  parameter int unsigned COLD_HOLD_CYCLES  = 4_000_000,
  parameter int unsigned WARM_PULSE_CYCLES = 2_000
) (
  input  logic          clk,
  input  logic          rst,
  input  pulseStrobes_t strobes,
  output logic          cntZero,
  output logic          sysRstN,
  output logic          initN
);

  localparam int unsigned MAX_CYCLES = (COLD_HOLD_CYCLES > WARM_PULSE_CYCLES) ?
                                       COLD_HOLD_CYCLES : WARM_PULSE_CYCLES;
  localparam int unsigned CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] COLD_LOAD = CNT_W'(COLD_HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WARM_LOAD = CNT_W'(WARM_PULSE_CYCLES - 1);

  logic [CNT_W-1:0] cntQ;
  logic             sysRstNQ;
  logic             initNQ;

  // Down-counter: loaded with width-1 on start, release fires when it reads zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (strobes.startCold) begin
      cntQ <= COLD_LOAD;
    end else if (strobes.startWarm) begin
      cntQ <= WARM_LOAD;
    end else if (cntQ != '0) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sysRstNQ <= 1'b1;
      initNQ   <= 1'b1;
    end else if (strobes.finish) begin
      sysRstNQ <= 1'b1;
      initNQ   <= 1'b1;
    end else begin
      if (strobes.startCold) sysRstNQ <= 1'b0;
      if (strobes.startWarm) initNQ   <= 1'b0;
    end
  end

  assign cntZero = (cntQ == '0);
  assign sysRstN = sysRstNQ;
  assign initN   = initNQ;

endmodule

// File: rtl/reset_pulse_top.sv
module reset_pulse_top
  import reset_pulse_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ       = 200_000_000,
  parameter int unsigned COLD_HOLD_CYCLES  = 4_000_000,
  parameter int unsigned WARM_PULSE_CYCLES = 2_000
) (
  input  logic clk,
  input  logic rst,
  input  logic reqValid,
  input  logic reqCold,
  input  logic sysRstSense,
  output logic sysRstN,
  output logic initN,
  output logic busy
);

  pulseStrobes_t strobes;
  logic          cntZero;

  reset_pulse_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .reqCold     (reqCold),
    .sysRstSense (sysRstSense),
    .cntZero     (cntZero),
    .strobes     (strobes),
    .busy        (busy)
  );

  reset_pulse_datapath #(
    .COLD_HOLD_CYCLES  (COLD_HOLD_CYCLES),
    .WARM_PULSE_CYCLES (WARM_PULSE_CYCLES)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cntZero (cntZero),
    .sysRstN (sysRstN),
    .initN   (initN)
  );

endmodule

// File: rtl/reset_pulse_checker.sv
module reset_pulse_checker #(
  parameter int unsigned CLK_FREQ_HZ       = 200_000_000,
  parameter int unsigned COLD_HOLD_CYCLES  = 4_000_000,
  parameter int unsigned WARM_PULSE_CYCLES = 2_000
) (
  input logic clk,
  input logic rst,
  input logic reqValid,
  input logic reqCold,
  input logic sysRstSense,
  input logic sysRstN,
  input logic initN,
  input logic busy
);

  // Fewest cycles covering 500 ns, rounded up.
  localparam longint unsigned MIN_WARM_CYCLES =
    (longint'(CLK_FREQ_HZ) * 500 + 64'd999_999_999) / 64'd1_000_000_000;

  int unsigned coldRun;
  int unsigned warmRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      coldRun <= 0;
      warmRun <= 0;
    end else begin
      coldRun <= sysRstN ? 0 : coldRun + 1;
      warmRun <= initN   ? 0 : warmRun + 1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sysRstN && initN && !busy));

  p_cold_width_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sysRstN) |-> (coldRun == COLD_HOLD_CYCLES));

  p_cold_refused_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && reqValid && reqCold && !sysRstSense) |=> (sysRstN && !busy));

  p_warm_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(initN) |-> (warmRun == WARM_PULSE_CYCLES));

  p_never_both_r5: assert property (@(posedge clk) disable iff (rst)
    (sysRstN || initN));

  p_busy_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    busy == (!sysRstN || !initN));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!$fell(sysRstN) && !$fell(initN)));

  p_warm_min_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(initN) |-> (longint'(warmRun) >= MIN_WARM_CYCLES));

  // R9 and R10: an idle warm request starts at once, whatever the sense level.
  p_warm_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && reqValid && !reqCold) |=> (!initN && busy && sysRstN));

endmodule

bind reset_pulse_top reset_pulse_checker #(
  .CLK_FREQ_HZ       (CLK_FREQ_HZ),
  .COLD_HOLD_CYCLES  (COLD_HOLD_CYCLES),
  .WARM_PULSE_CYCLES (WARM_PULSE_CYCLES)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .reqValid    (reqValid),
  .reqCold     (reqCold),
  .sysRstSense (sysRstSense),
  .sysRstN     (sysRstN),
  .initN       (initN),
  .busy        (busy)
);

// File: tb/reset_pulse_top_tb_top.sv
module reset_pulse_top_tb_top;

  localparam int unsigned CLK_HZ   = 200_000_000;
  localparam int unsigned COLD_LEN = 400;
  localparam int unsigned WARM_LEN = 120;
  localparam int unsigned MIN_WARM = 100;  // 500 ns at 200 MHz

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqCold = 1'b0;
  logic sysRstSense = 1'b1;
  logic sysRstN;
  logic initN;
  logic busy;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Reference model state
  logic expSys = 1'b1;
  logic expInit = 1'b1;
  int   remain = 0;

  always #2.5 clk = ~clk;

  reset_pulse_top #(
    .CLK_FREQ_HZ       (CLK_HZ),
    .COLD_HOLD_CYCLES  (COLD_LEN),
    .WARM_PULSE_CYCLES (WARM_LEN)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .reqCold     (reqCold),
    .sysRstSense (sysRstSense),
    .sysRstN     (sysRstN),
    .initN       (initN),
    .busy        (busy)
  );

  function automatic bit accepts(input bit v, input bit c, input bit s, input int rem);
    return v && (rem == 0) && (!c || s);
  endfunction

  function automatic int pulseLen(input bit c);
    return c ? COLD_LEN : WARM_LEN;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic checkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Reference model, updated from the sampled inputs.
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      expSys = 1'b1; expInit = 1'b1; remain = 0;
    end else if (remain != 0) begin
      remain--;
      if (remain == 0) begin expSys = 1'b1; expInit = 1'b1; end
    end else if (accepts(reqValid, reqCold, sysRstSense, remain)) begin
      remain = pulseLen(reqCold);
      if (reqCold) expSys = 1'b0; else expInit = 1'b0;
    end
  end

  // Continuous cycle-by-cycle comparison (R2, R4, R6).
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 sysRstN", sysRstN, expSys);
      check("R4 initN", initN, expInit);
      check("R6 busy", busy, remain != 0);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  task automatic request(input bit c, input bit s);
    reqValid = 1'b1; reqCold = c; sysRstSense = s;
    @(negedge clk);
    reqValid = 1'b0; sysRstSense = 1'b1;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check("R1 sysRstN", sysRstN, 1'b1);
    check("R1 initN", initN, 1'b1);
    check("R1 busy", busy, 1'b0);

    // R3: cold refused while sense is low
    request(1'b1, 1'b0);
    check("R3 sysRstN", sysRstN, 1'b1);
    check("R3 busy", busy, 1'b0);

    // R10: warm accepted with sense low; R7/R5: cold during warm ignored
    request(1'b0, 1'b0);
    check("R10 initN", initN, 1'b0);
    begin
      int lowLen = 1;
      request(1'b1, 1'b1);
      lowLen++;
      while (!initN) begin
        check("R5 R7 sysRstN held", sysRstN, 1'b1);
        @(negedge clk);
        lowLen++;
      end
      lowLen--;
      checkInt("R7 warm length", lowLen, WARM_LEN);
      checks++;
      if (lowLen < MIN_WARM) begin
        failures++;
        $display("FAIL R8 actual=%0d expected>=%0d", lowLen, MIN_WARM);
      end
    end

    // R9: cold request in the first idle cycle, then measure R2 width
    request(1'b0, 1'b1);
    while (busy) @(negedge clk);
    request(1'b1, 1'b1);
    check("R9 sysRstN", sysRstN, 1'b0);
    begin
      int lowLen = 0;
      while (!sysRstN) begin
        check("R5 initN held", initN, 1'b1);
        if (lowLen == 10) request(1'b0, 1'b1);
        else @(negedge clk);
        lowLen++;
      end
      checkInt("R2 cold length", lowLen, COLD_LEN);
    end

    // Random mixed traffic against the reference model
    for (int i = 0; i < 30000; i++) begin
      reqValid    = ($urandom % 40) == 0;
      reqCold     = $urandom % 2;
      sysRstSense = ($urandom % 4) != 0;
      @(negedge clk);
    end
    reqValid = 1'b0;
    waitIdle();
    @(negedge clk);
    finishRun();
  end

endmodule